// File: doc/BRIEF.md
# Two-Pattern Delay-Test Scan Controller

This block owns a chain of mux-D scan cells and sequences a complete two-pattern transition test over it. After a start pulse it serially loads an initialisation pattern, forms a launch pattern, captures the response of the combinational logic to that launch pattern, and serially unloads the response while new bits enter from the scan input. A done flag marks the end of each run.

Two launch styles share the same chain and are picked per run. With launch-on-capture the chain takes one functional capture, so the logic's response to the first pattern becomes the second pattern. With launch-on-shift the chain moves by one more bit, so the second pattern is the first one displaced by a single cell. Because of this, only 2^(n+1) of the 2^(2n) ordered pairs can be produced in launch-on-shift mode for an n-cell chain. The cell outputs drive the logic under test and its outputs come back on the functional inputs.

Top module: `dts_scan_ctrl`

## Requirements
- R1: After reset the cell outputs, scan_out_o, scan_en_o and done_o are all 0.
- R2: The start_i edge that begins a run performs no shift. The next CHAIN_LEN edges shift with scan_en_o high: each cell i>0 takes cell i-1, cell 0 takes scan_in_i, and the first bit presented ends in cell CHAIN_LEN-1.
- R3: With mode_i=0 (launch-on-capture), the launch edge loads every cell from func_i, with scan_en_o low.
- R4: With mode_i=1 (launch-on-shift), the launch edge performs one more shift, with scan_en_o high and cell 0 taking scan_in_i.
- R5: The edge after launch always loads func_i into the chain, with scan_en_o low. func_i at that edge is the logic's response to the launch pattern.
- R6: The next CHAIN_LEN edges shift the chain with scan_en_o high. Before each of them scan_out_o shows the captured response, cell CHAIN_LEN-1 first.
- R7: done_o is high for exactly one cycle, starting at the final unload edge, which is edge 2*CHAIN_LEN+2 after the start edge. It is low for the rest of the run.
- R8: mode_i is sampled only on the start edge. Changes to it during a run have no effect.
- R9: A start_i pulse while a run is in progress is ignored. The run length and the data it produces are unchanged.
- R10: While idle the chain holds its contents whatever scan_in_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a test run (taken only while idle) |
| mode_i | input | 1 | 0 launch-on-capture, 1 launch-on-shift |
| scan_in_i | input | 1 | Serial data into cell 0 |
| func_i | input | CHAIN_LEN | Functional responses from the logic under test |
| state_o | output | CHAIN_LEN | Cell outputs driving the logic under test |
| scan_en_o | output | 1 | Scan enable in effect for the current cycle |
| scan_out_o | output | 1 | Serial data from cell CHAIN_LEN-1 |
| done_o | output | 1 | One-cycle end-of-run flag |

## Verification
The bench builds the block with the default CHAIN_LEN of 8. This is long enough that a wrong shift direction, an off-by-one load or unload count, or a reversed unload order each gives a visibly wrong byte. It is also short enough that whole runs in both modes fit in a few dozen cycles. The logic under test is a rotate-left by one XORed with 0xA5. This function is not its own inverse, so a missing or doubled capture is caught. Mode flips and start pulses in the middle of a run check that each run follows only the mode it started with.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic {
    LAUNCH_CAPTURE = 1'b0,
    LAUNCH_SHIFT   = 1'b1
  } launch_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LOAD    = 3'd1,
    PH_LAUNCH  = 3'd2,
    PH_CAPTURE = 3'd3,
    PH_UNLOAD  = 3'd4
  } phase_e;
endpackage

// File: rtl/dts_scan_cell.sv
module dts_scan_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic se_i,
  input  logic func_d_i,
  input  logic scan_d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (en_i) q_o <= se_i ? scan_d_i : func_d_i;
  end
endmodule

// File: rtl/dts_sequencer.sv
module dts_sequencer
  import dts_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  output logic en_o,
  output logic se_o,
  output logic done_o
);
  localparam int unsigned CW = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

  phase_e       phase_q;
  launch_mode_e mode_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      mode_q  <= LAUNCH_CAPTURE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_LOAD;
          mode_q  <= launch_mode_e'(mode_i);
          cnt_q   <= '0;
        end
        PH_LOAD: begin
          if (cnt_q == LAST) begin
            phase_q <= PH_LAUNCH;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_LAUNCH:  phase_q <= PH_CAPTURE;
        PH_CAPTURE: phase_q <= PH_UNLOAD;
        PH_UNLOAD: begin
          if (cnt_q == LAST) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    en_o = (phase_q != PH_IDLE);
    unique case (phase_q)
      PH_LOAD, PH_UNLOAD: se_o = 1'b1;
      PH_LAUNCH:          se_o = (mode_q == LAUNCH_SHIFT);
      default:            se_o = 1'b0;
    endcase
  end

  // R8: launch style frozen for the whole run
  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |=> $stable(mode_q));
  // R7: single-cycle done, only out of unload
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_unload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(phase_q) == PH_UNLOAD) && (phase_q == PH_IDLE));
  // R5: capture always follows launch
  assert_launch_then_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LAUNCH) |=> (phase_q == PH_CAPTURE) && !se_o);
  // R9: start inside a run does not restart the load
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LOAD && cnt_q != LAST) |=> (phase_q == PH_LOAD) && (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dts_scan_ctrl.sv
module dts_scan_ctrl #(
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 mode_i,
  input  logic                 scan_in_i,
  input  logic [CHAIN_LEN-1:0] func_i,
  output logic [CHAIN_LEN-1:0] state_o,
  output logic                 scan_en_o,
  output logic                 scan_out_o,
  output logic                 done_o
);
  logic en_w, se_w;
  logic [CHAIN_LEN-1:0] chain_w;

  dts_sequencer #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .mode_i (mode_i),
    .en_o   (en_w),
    .se_o   (se_w),
    .done_o (done_o)
  );

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    logic scan_d;
    if (i == 0) begin : g_head
      assign scan_d = scan_in_i;
    end else begin : g_body
      assign scan_d = chain_w[i-1];
    end
    dts_scan_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_w),
      .se_i    (se_w),
      .func_d_i(func_i[i]),
      .scan_d_i(scan_d),
      .q_o     (chain_w[i])
    );
  end

  assign state_o    = chain_w;
  assign scan_out_o = chain_w[CHAIN_LEN-1];
  assign scan_en_o  = se_w & en_w;

  // R10: idle chain holds
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |=> $stable(chain_w));
  // R2/R4/R6: every enabled scan cycle moves data one cell toward scan-out
  assert_shift_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && se_w) |=> (chain_w[CHAIN_LEN-1:1] == $past(chain_w[CHAIN_LEN-2:0]))
                       && (chain_w[0] == $past(scan_in_i)));
  // R3/R5: functional load takes func_i
  assert_func_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && !se_w) |=> (chain_w == $past(func_i)));
endmodule

// File: tb/dts_scan_ctrl_test.sv
module dts_scan_ctrl_test;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, sin = 1'b0;
  logic [N-1:0] func, state;
  logic sen, sout, done;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  function automatic logic [N-1:0] cut_f(input logic [N-1:0] x);
    return {x[N-2:0], x[N-1]} ^ 8'hA5;
  endfunction
  assign func = cut_f(state);

  dts_scan_ctrl #(.CHAIN_LEN(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .scan_in_i(sin), .func_i(func), .state_o(state), .scan_en_o(sen),
    .scan_out_o(sout), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  // full run; mode flipped and start pulsed mid-run to probe R8/R9
  task automatic run_test(input logic m, input logic [N-1:0] p, input logic extra,
                          input logic [N-1:0] nxt);
    logic [N-1:0] launched, cap;
    start = 1'b1; mode = m;
    step;
    start = 1'b0; mode = ~m;
    for (int k = 0; k < N; k++) begin
      chk("R2 scan_en during load", sen, 1);
      sin = p[N-1-k];
      start = (k == 3);
      step;
    end
    start = 1'b0;
    chk("R2 loaded pattern", state, p);
    chk("R3/R4/R8 launch scan_en", sen, m);
    sin = extra;
    launched = m ? {p[N-2:0], extra} : cut_f(p);
    step;
    chk(m ? "R4 skewed launch pattern" : "R3 broadside launch pattern", state, launched);
    chk("R5 capture scan_en low", sen, 0);
    cap = cut_f(launched);
    step;
    chk("R5 captured response", state, cap);
    for (int k = 0; k < N; k++) begin
      chk("R6 unload bit", sout, cap[N-1-k]);
      chk("R6 unload scan_en", sen, 1);
      chk("R7 done low in run", done, 0);
      sin = nxt[N-1-k];
      step;
    end
    chk("R7 done pulse", done, 1);
    chk("R6 next pattern shifted in", state, nxt);
    chk("R9 back to idle", sen, 0);
    step;
    chk("R7 done one cycle", done, 0);
  endtask

  task automatic idle_test;
    logic [N-1:0] held;
    held = state;
    for (int k = 0; k < 5; k++) begin
      sin = k[0];
      step;
      chk("R10 idle hold", state, held);
      chk("R10 idle scan_en", sen, 0);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset state", state, 0);
    chk("R1 reset scan_out", sout, 0);
    chk("R1 reset scan_en", sen, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    step;
    idle_test();
    run_test(1'b0, 8'h3C, 1'b1, 8'h96);
    idle_test();
    run_test(1'b1, 8'hB1, 1'b1, 8'h0F);
    run_test(1'b1, 8'h80, 1'b0, 8'hFF);
    run_test(1'b0, 8'h00, 1'b0, 8'h5A);
    idle_test();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule